// File: doc/BRIEF.md
# Multichannel Converter Sequence Reader

This block sits on the host side of a four-channel, 14-bit, simultaneous-sampling converter that has a parallel bus. When the host asks for a sequence, the block wakes the converter if it is in standby. It waits out the wake-up time and then drives the convert-start line low for a fixed width. After that it waits for the converter to report that conversion is finished. It then fetches one result for each channel picked by the channel mask, using a chip-select and read strobe. Each result goes into a small register bank, and the block raises a one-cycle completion pulse.

Two read orderings are offered. Burst mode waits until the converter's busy line falls and then reads all selected channels back to back. Per-channel mode performs one read after each end-of-conversion pulse, while the rest of the sequence is still converting. In both modes the selected channels are read in ascending channel order. Between sequences the converter can be put back into standby. A programmable timeout aborts a sequence in which the converter never reports completion.

All converter-side inputs are taken as synchronous to the block clock. The result bank is a plain register output. It has no handshake: a value stays valid from its write until the next sequence overwrites it.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset, chip-select, read strobe, write strobe and convert-start are all high (inactive), the standby control is low (converter in standby), busy_o, done_o and err_o are low, and every result slot reads zero.
- R2: A start_i pulse is accepted only while the block is idle and chan_mask_i is non-zero. A start with an all-zero mask, or a start during a running sequence, has no effect: no convert-start, no reads, and no change to the running sequence's results.
- R3: If the converter is in standby when a start is accepted, the standby control goes high at once and convert-start is held off for WAKE_CYC = ceil(CLK_KHZ*WAKE_NS/10^6) cycles. If the converter is awake, convert-start falls on the clock after acceptance. Convert-start stays low for ceil(CLK_KHZ*CONVST_NS/10^6) cycles and is never low while in standby.
- R4: Burst mode (mode_i = 0): no read starts until the converter's busy line has fallen. Exactly one read is then made per selected channel.
- R5: Per-channel mode (mode_i = 1): each read starts only after a new falling edge of the active-low end-of-conversion input. Exactly one read is made per selected channel.
- R6: Every read drives chip-select and read strobe low together for rd_len_i cycles (a value of 0 counts as 1). Selected channels are read in ascending index order. The bus value present at the rising edge of the read strobe is stored in slot k of res_o (bits 14k+13 down to 14k) for channel k. Unselected slots keep their previous contents.
- R7: done_o is high for exactly one cycle, in the same cycle that the final result becomes visible on res_o.
- R8: When stby_en_i was high at start, the standby control returns low at the end of the sequence. When it was low, the converter stays awake.
- R9: If the awaited busy fall or end-of-conversion pulse does not arrive within tmo_lim_i cycles after convert-start is released, the sequence is aborted. err_o then goes high, no done_o pulse is given, nothing further is stored, and standby follows R8. err_o clears when the next start is accepted.
- R10: Results pass through unaltered in two's-complement form (for example 0x3FFF, 0x0000, 0x2000, 0x1FFF) and stay stable while the block is idle.
- R11: The write strobe to the converter is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Sequence request, one cycle |
| chan_mask_i | input | NCH | Channels to read, bit k = channel k |
| mode_i | input | 1 | 0 burst read after busy falls, 1 read per end-of-conversion |
| stby_en_i | input | 1 | Return converter to standby after the sequence |
| rd_len_i | input | RL_W | Read strobe length in cycles (0 counts as 1) |
| tmo_lim_i | input | TMO_W | Wait limit in cycles before abort |
| adc_db_i | input | DW | Converter data bus |
| adc_busy_i | input | 1 | Converter busy, high during conversion |
| adc_eoc_ni | input | 1 | Converter end-of-conversion pulse, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout abort flag |
| res_o | output | NCH*DW | Result bank, slot k at bits 14k+13:14k |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_wr_no | output | 1 | Converter write strobe, held high |
| adc_convst_no | output | 1 | Convert start, active low |
| adc_stby_no | output | 1 | Standby control, low puts converter in standby |

## Verification
The hardest cases to reach are the ones where the converter misbehaves or the host misbehaves in the middle of a run. One is a converter that never reports completion, so the timeout must abort while the block is still waiting. The other is a second start request arriving during the convert phase. The bench's converter model can be switched to stay silent after convert-start, which drives the block into its timeout path. A later healthy run then shows that the error clears. The bench also pulses start, with a different mask, while convert-start is still low. It then confirms that only the original channels were read and that a single done pulse followed.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAKE = 3'd1,
    S_CONV = 3'd2,
    S_WAIT = 3'd3,
    S_STRB = 3'd4,
    S_GAP  = 3'd5
  } seq_st_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int khz, input int ns);
    longint t;
    t = (longint'(khz) * longint'(ns) + 64'sd999999) / 64'sd1000000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction

endpackage

// File: rtl/adcseq_tmr.sv
module adcseq_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R3

endmodule

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign sel_o[g]    = req_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | req_i[g];
  end

endmodule

// File: rtl/adcseq_bank.sv
module adcseq_bank #(
  parameter int NCH = 4,
  parameter int DW  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    we_i,
  input  logic [DW-1:0]     din_i,
  output logic [NCH*DW-1:0] res_o
);

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     slot_q <= '0;
      else if (we_i[k]) slot_q <= din_i;
    end
    assign res_o[k*DW +: DW] = slot_q;
  end

  AST_BANK_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i)); // R6

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int DW         = 14,
  parameter int CLK_KHZ    = 250000,
  parameter int WAKE_NS    = 1000,
  parameter int CONVST_NS  = 40,
  parameter int RL_W       = 4,
  parameter int TMO_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NCH-1:0]    chan_mask_i,
  input  logic              mode_i,
  input  logic              stby_en_i,
  input  logic [RL_W-1:0]   rd_len_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic [DW-1:0]     adc_db_i,
  input  logic              adc_busy_i,
  input  logic              adc_eoc_ni,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [NCH*DW-1:0] res_o,
  output logic              adc_cs_no,
  output logic              adc_rd_no,
  output logic              adc_wr_no,
  output logic              adc_convst_no,
  output logic              adc_stby_no
);

  localparam int WAKE_CYC = ns_to_cyc(CLK_KHZ, WAKE_NS);
  localparam int CV_CYC   = ns_to_cyc(CLK_KHZ, CONVST_NS);
  localparam int PH_MAX   = ((WAKE_CYC > CV_CYC) ? WAKE_CYC : CV_CYC) + (1 << RL_W);
  localparam int PH_W     = $clog2(PH_MAX + 1);

  seq_st_e          st_q;
  logic [NCH-1:0]   rem_q;
  logic             mode_q;
  logic             sen_q;
  logic [RL_W-1:0]  rl_q;
  logic [TMO_W-1:0] lim_q;
  logic             bsy_d_q;
  logic             eoc_d_q;
  logic             cs_q, rd_q, cv_q, sb_q;
  logic             done_q, err_q;

  logic             ph_load, ph_zero;
  logic [PH_W-1:0]  ph_val;
  logic             to_load, to_zero;
  logic [NCH-1:0]   sel;
  logic [NCH-1:0]   bank_we;
  logic [RL_W-1:0]  rl_eff;
  logic             start_acc, last_rd, busy_fall, eoc_fall, evt;

  assign start_acc = (st_q == S_IDLE) && start_i && (chan_mask_i != '0);
  assign rl_eff    = (rl_q == '0) ? RL_W'(1) : rl_q;
  assign last_rd   = ((rem_q & ~sel) == '0);
  assign busy_fall = bsy_d_q & ~adc_busy_i;
  assign eoc_fall  = eoc_d_q & ~adc_eoc_ni;
  assign evt       = mode_q ? eoc_fall : busy_fall;
  assign bank_we   = (st_q == S_STRB && ph_zero) ? sel : '0;

  // phase timer loads
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    to_load = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_acc) begin
        ph_load = 1'b1;
        ph_val  = sb_q ? PH_W'(CV_CYC - 1) : PH_W'(WAKE_CYC - 1);
      end
      S_WAKE: if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = PH_W'(CV_CYC - 1);
      end
      S_CONV: if (ph_zero) to_load = 1'b1;
      S_WAIT: if (evt) begin
        ph_load = 1'b1;
        ph_val  = {{(PH_W - RL_W){1'b0}}, rl_eff} - PH_W'(1);
      end
      S_GAP: begin
        ph_load = 1'b1;
        ph_val  = {{(PH_W - RL_W){1'b0}}, rl_eff} - PH_W'(1);
      end
      default: ;
    endcase
  end

  adcseq_tmr #(.W(PH_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_load),
    .val_i  (ph_val),
    .zero_o (ph_zero)
  );

  adcseq_tmr #(.W(TMO_W)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (to_load),
    .val_i  (lim_q),
    .zero_o (to_zero)
  );

  adcseq_pick #(.N(NCH)) u_pick (
    .req_i (rem_q),
    .sel_o (sel)
  );

  adcseq_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .din_i  (adc_db_i),
    .res_o  (res_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rem_q   <= '0;
      mode_q  <= 1'b0;
      sen_q   <= 1'b0;
      rl_q    <= '0;
      lim_q   <= '0;
      bsy_d_q <= 1'b0;
      eoc_d_q <= 1'b1;
      cs_q    <= 1'b1;
      rd_q    <= 1'b1;
      cv_q    <= 1'b1;
      sb_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      bsy_d_q <= adc_busy_i;
      eoc_d_q <= adc_eoc_ni;
      done_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_acc) begin
          rem_q  <= chan_mask_i;
          mode_q <= mode_i;
          sen_q  <= stby_en_i;
          rl_q   <= rd_len_i;
          lim_q  <= tmo_lim_i;
          err_q  <= 1'b0;
          if (!sb_q) begin
            sb_q <= 1'b1;
            st_q <= S_WAKE;
          end else begin
            cv_q <= 1'b0;
            st_q <= S_CONV;
          end
        end
        S_WAKE: if (ph_zero) begin
          cv_q <= 1'b0;
          st_q <= S_CONV;
        end
        S_CONV: if (ph_zero) begin
          cv_q <= 1'b1;
          st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (evt) begin
            cs_q <= 1'b0;
            rd_q <= 1'b0;
            st_q <= S_STRB;
          end else if (to_zero) begin
            err_q <= 1'b1;
            sb_q  <= ~sen_q;
            st_q  <= S_IDLE;
          end
        end
        S_STRB: if (ph_zero) begin
          cs_q  <= 1'b1;
          rd_q  <= 1'b1;
          rem_q <= rem_q & ~sel;
          if (last_rd) begin
            done_q <= 1'b1;
            sb_q   <= ~sen_q;
            st_q   <= S_IDLE;
          end else begin
            st_q <= mode_q ? S_WAIT : S_GAP;
          end
        end
        S_GAP: begin
          cs_q <= 1'b0;
          rd_q <= 1'b0;
          st_q <= S_STRB;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != S_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign adc_cs_no     = cs_q;
  assign adc_rd_no     = rd_q;
  assign adc_wr_no     = 1'b1;
  assign adc_convst_no = cv_q;
  assign adc_stby_no   = sb_q;

  AST_REQ_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE) |=> $stable(mode_q)); // R2
  AST_CONVST_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_convst_no |-> adc_stby_no); // R3
  AST_NO_READ_IN_CONVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_convst_no |-> adc_rd_no); // R4
  AST_STROBE_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no == adc_rd_no); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_STBY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sen_q) |-> !adc_stby_no); // R8
  AST_ERR_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o); // R9
  AST_RES_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !start_i) |=> $stable(res_o)); // R10

endmodule

// File: tb/adcseq_ctrl_bench.sv
module adcseq_ctrl_bench;

  localparam int CONV_T   = 20;
  localparam int WAKE_EXP = (250000 * 1000 + 999999) / 1000000;
  localparam int CV_EXP   = (250000 * 40 + 999999) / 1000000;
  localparam int WD_CYC   = 150000;

  typedef struct packed {
    logic [3:0]  mask;
    logic        mode;
    logic        sen;
    logic [3:0]  rdlen;
    logic [13:0] d3;
    logic [13:0] d2;
    logic [13:0] d1;
    logic [13:0] d0;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'hF, 1'b0, 1'b1, 4'd3,  14'h1FFF, 14'h2000, 14'h0000, 14'h3FFF},
    '{4'h5, 1'b1, 1'b1, 4'd1,  14'h0ABC, 14'h0789, 14'h0456, 14'h0123},
    '{4'hA, 1'b0, 1'b0, 4'd0,  14'h1111, 14'h2222, 14'h3333, 14'h0444},
    '{4'h8, 1'b1, 1'b0, 4'd5,  14'h2AAA, 14'h1555, 14'h0F0F, 14'h30F0},
    '{4'hF, 1'b1, 1'b1, 4'd2,  14'h3001, 14'h0FFE, 14'h2468, 14'h1357},
    '{4'h1, 1'b0, 1'b1, 4'd15, 14'h0001, 14'h0002, 14'h0003, 14'h3FFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mask_in = '0;
  logic        mode_in = 1'b0;
  logic        sen_in = 1'b0;
  logic [3:0]  rl_in = '0;
  logic [15:0] lim_in = '0;
  logic [13:0] db;
  logic        busy_o, done_o, err_o;
  logic [55:0] res_o;
  logic        cs_n, rd_n, wr_n, cv_n, sb_n;

  // converter model state (written only by the model process)
  logic        m_busy = 1'b0;
  logic        m_eoc_n = 1'b1;
  logic [3:0]  crem = '0, rrem = '0;
  int          ccnt = 0, eavail = 0, run = 0, cvc = 0;
  logic        cv_prev = 1'b1, rd_prev = 1'b1;
  int          bad_len = 0, nreads = 0, mis = 0, wr_low = 0, cv_sb = 0;
  int          cv_w = 0, cv_falls = 0, viol = 0, ndone = 0;

  // bench-set model configuration
  logic [3:0]  cur_mask = '0;
  logic        cur_mode = 1'b0;
  logic        dead = 1'b0;
  int          exp_len = 1;
  logic [13:0] mdata [4];
  logic [13:0] er [4];
  logic        in_sb;
  int          nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  function automatic int lowidx(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic logic [3:0] lowbit(input logic [3:0] m);
    return m & (~m + 4'd1);
  endfunction

  assign db = (!cs_n && !rd_n) ? mdata[lowidx(rrem)] : 14'h0;

  adcseq_ctrl u_adcseq_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .chan_mask_i   (mask_in),
    .mode_i        (mode_in),
    .stby_en_i     (sen_in),
    .rd_len_i      (rl_in),
    .tmo_lim_i     (lim_in),
    .adc_db_i      (db),
    .adc_busy_i    (m_busy),
    .adc_eoc_ni    (m_eoc_n),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .res_o         (res_o),
    .adc_cs_no     (cs_n),
    .adc_rd_no     (rd_n),
    .adc_wr_no     (wr_n),
    .adc_convst_no (cv_n),
    .adc_stby_no   (sb_n)
  );

  // converter model and monitors, away from the active edge
  always @(negedge clk) begin
    m_eoc_n = 1'b1;
    if (cv_prev && !cv_n) begin
      cv_falls++;
      m_busy = !dead;
      ccnt = 0;
      crem = cur_mask;
      rrem = cur_mask;
      eavail = 0;
    end else if (m_busy) begin
      ccnt++;
      if (ccnt == CONV_T) begin
        ccnt = 0;
        crem = crem & ~lowbit(crem);
        m_eoc_n = 1'b0;
        eavail++;
        if (crem == '0) m_busy = 1'b0;
      end
    end
    if (rd_prev && !rd_n) begin
      if (!cur_mode && m_busy) viol++;
      if (cur_mode) begin
        if (eavail == 0) viol++;
        else eavail--;
      end
    end
    if (!rd_n) run++;
    else if (run != 0) begin
      if (run != exp_len) bad_len++;
      nreads++;
      rrem = rrem & ~lowbit(rrem);
      run = 0;
    end
    if (!cv_n) cvc++;
    else if (cvc != 0) begin
      cv_w = cvc;
      cvc = 0;
    end
    if (cs_n != rd_n) mis++;
    if (!wr_n) wr_low++;
    if (!cv_n && !sb_n) cv_sb++;
    if (done_o) ndone++;
    cv_prev = cv_n;
    rd_prev = rd_n;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] exp_flat();
    return {er[3], er[2], er[1], er[0]};
  endfunction

  task automatic run_seq(input vec_t v, input int lim, input bit poke, input bit expect_err);
    int k, b_len, b_rd, b_mis, b_viol, b_done, b_sb, w;
    mdata[0] = v.d0; mdata[1] = v.d1; mdata[2] = v.d2; mdata[3] = v.d3;
    cur_mask = v.mask;
    cur_mode = v.mode;
    exp_len  = (v.rdlen == 0) ? 1 : int'(v.rdlen);
    b_len = bad_len; b_rd = nreads; b_mis = mis; b_viol = viol; b_done = ndone; b_sb = cv_sb;
    mask_in = v.mask; mode_in = v.mode; sen_in = v.sen; rl_in = v.rdlen;
    lim_in = 16'(lim);
    start = 1'b1;
    tick();
    start = 1'b0;
    k = 1;
    while (cv_n && k < 2000) begin
      tick();
      k++;
    end
    // R3 convert-start delay depends on standby state at start
    chk(k == (in_sb ? WAKE_EXP + 1 : 1), "R3 start-to-convert cycles", k, in_sb ? WAKE_EXP + 1 : 1);
    if (poke) begin
      mask_in = 4'h2;
      start = 1'b1;
      tick();
      start = 1'b0;
      mask_in = v.mask;
    end
    w = 0;
    while (!done_o && !err_o && w < 3000) begin
      tick();
      w++;
    end
    if (expect_err) begin
      chk(err_o == 1'b1, "R9 timeout raises error", err_o, 1);
      chk(ndone == b_done, "R9 no done on abort", ndone - b_done, 0);
      chk(res_o == exp_flat(), "R9 results untouched on abort", res_o, exp_flat());
    end else begin
      for (int i = 0; i < 4; i++) if (v.mask[i]) er[i] = mdata[i];
      chk(done_o == 1'b1, "R7 done pulse seen", done_o, 1);
      chk(res_o == exp_flat(), v.mode ? "R5 R6 results per-channel mode" : "R4 R6 results burst mode",
          res_o, exp_flat());
      chk(nreads - b_rd == $countones(v.mask), v.mode ? "R5 read count" : "R4 read count",
          nreads - b_rd, $countones(v.mask));
      chk(viol == b_viol, v.mode ? "R5 read before end-of-conversion" : "R4 read while busy",
          viol - b_viol, 0);
      chk(bad_len == b_len, "R6 strobe length", bad_len - b_len, 0);
      chk(mis == b_mis, "R6 chip-select with read strobe", mis - b_mis, 0);
      chk(err_o == 1'b0, "R9 error clear on good run", err_o, 0);
    end
    chk(cv_w == CV_EXP, "R3 convert-start width", cv_w, CV_EXP);
    chk(cv_sb == b_sb, "R3 convert while in standby", cv_sb - b_sb, 0);
    tick();
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 done one cycle then idle", {done_o, busy_o}, 0);
    chk(ndone - b_done == (expect_err ? 0 : 1), "R2 R7 single done per sequence", ndone - b_done,
        expect_err ? 0 : 1);
    chk(sb_n == !v.sen, "R8 standby after sequence", sb_n, !v.sen);
    in_sb = v.sen;
  endtask

  // watchdog: counts as a failed check and still reports
  initial begin
    repeat (WD_CYC) @(negedge clk);
    $display("FAIL watchdog expired actual=%0d expected=finish", WD_CYC);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    int b_cv;
    bit bad;
    vec_t pv;
    for (int i = 0; i < 4; i++) begin
      er[i] = '0;
      mdata[i] = '0;
    end
    in_sb = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(cs_n && rd_n && cv_n, "R1 strobes inactive in reset", {cs_n, rd_n, cv_n}, 3'b111);
    chk(sb_n == 1'b0, "R1 standby in reset", sb_n, 0);
    rst_n = 1'b1;
    tick();
    chk({busy_o, done_o, err_o} == 3'b000, "R1 status after reset", {busy_o, done_o, err_o}, 0);
    chk(res_o == '0, "R1 results zero", res_o, 0);
    chk(cs_n && rd_n && cv_n && !sb_n, "R1 converter pins after reset", {cs_n, rd_n, cv_n, sb_n}, 4'b1110);

    for (int i = 0; i < 6; i++) run_seq(VECS[i], 1000, 1'b0, 1'b0);

    // R10 results stable while idle
    snap = res_o;
    bad = 1'b0;
    for (int i = 0; i < 25; i++) begin
      tick();
      if (res_o != snap) bad = 1'b1;
    end
    chk(!bad, "R10 results hold while idle", res_o, snap);

    // R2 start during a sequence is ignored
    pv = '{4'h3, 1'b0, 1'b0, 4'd2, 14'h0AAA, 14'h0BBB, 14'h0CCC, 14'h0DDD};
    run_seq(pv, 1000, 1'b1, 1'b0);

    // R2 start with empty mask is ignored
    b_cv = cv_falls;
    mask_in = 4'h0;
    start = 1'b1;
    tick();
    start = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (busy_o || !rd_n) bad = 1'b1;
    end
    chk(!bad, "R2 empty mask leaves block idle", bad, 0);
    chk(cv_falls == b_cv, "R2 empty mask gives no convert", cv_falls - b_cv, 0);

    // R9 silent converter times out
    dead = 1'b1;
    pv = '{4'hF, 1'b0, 1'b1, 4'd1, 14'h1234, 14'h1234, 14'h1234, 14'h1234};
    run_seq(pv, 50, 1'b0, 1'b1);
    dead = 1'b0;

    // R9 recovery clears error, R5 from standby
    pv = '{4'h6, 1'b1, 1'b1, 4'd3, 14'h0F00, 14'h00F0, 14'h000F, 14'h3F00};
    run_seq(pv, 1000, 1'b0, 1'b0);

    chk(wr_low == 0, "R11 write strobe held high", wr_low, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule